// File: doc/BRIEF.md
# Product-Term Sharing Array

This block is the combinational logic core of one logic block in a programmable-logic model. A wide input bus feeds an AND array. In that array every product term may pick any input in true or inverted form. The logic product terms are grouped into fixed clusters of five, and each macrocell owns one cluster. A wrap-around steering network lets each macrocell gather whole clusters from its own position and the three positions on either side. One function can therefore collect up to seven clusters, or 35 terms. The block produces one sum-of-products bit for each macrocell.

A small function can skip the steering network through a per-macrocell bypass, which uses the macrocell's own cluster alone. A separate set of three control product terms is built from the same input bus and comes out unchanged, for use as shared reset, clock, clock-enable and output-enable signals. If two macrocells claim the same cluster, the block flags that cluster and the cluster then feeds no macrocell. All configuration arrives as static input vectors. Nothing in the block is clocked.

Top module: `pts_array`

## Requirements
- R1: Literal `2*i` of a term's mask is input `pt_in[i]` and literal `2*i+1` is its complement. A term is the AND of the literals its mask selects.
- R2: A term whose mask selects no literal evaluates to 1.
- R3: Logic term `t` lives at mask bits `[t*136 +: 136]` and belongs to cluster `t/5`. Each `mc_sum[m]` is the OR of every term in the clusters granted to macrocell `m`.
- R4: Bit `k` (0..6) of macrocell `m`'s 7-bit steering field `take_sel[m*7 +: 7]` claims cluster `(m+k-3) mod 32`, so bit 3 is the macrocell's own cluster. Claims wrap between macrocell 31 and macrocell 0.
- R5: One macrocell can claim all seven clusters in its window, which gives a single function 35 terms.
- R6: When `bypass_en[m]` is 1, macrocell `m` claims only its own cluster and its steering field has no effect.
- R7: When two or more macrocells claim a cluster, `claim_err` is set for that cluster and the cluster contributes to no macrocell. A cluster with one claimant has its `claim_err` bit at 0.
- R8: An unclaimed cluster contributes to no sum, and a macrocell with no granted cluster outputs 0.
- R9: `ctrl_pt[j]` is the product term defined by `ctrl_mask[j*136 +: 136]` under the rules of R1 and R2. It does not depend on steering or bypass.
- R10: All outputs follow their inputs combinationally, with no clock and no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pt_in | input | 68 | Global input bus |
| lit_mask | input | 21760 | Literal-select masks, 136 bits for each of the 160 logic terms |
| ctrl_mask | input | 408 | Literal-select masks for the 3 control terms |
| take_sel | input | 224 | Steering fields, 7 bits per macrocell |
| bypass_en | input | 32 | Per-macrocell bypass flag |
| mc_sum | output | 32 | Sum-of-products output per macrocell |
| ctrl_pt | output | 3 | Control product terms |
| claim_err | output | 32 | Per-cluster multiple-claim flag |

## Verification
Directed patterns switch off every term except a chosen few. With this set-up, a set sum bit shows exactly which cluster reached which macrocell. It separates the two wrap directions, the far edges of a seven-cluster window, a bypass whose steering field points elsewhere, and a double claim that has to starve the macrocell. Single-literal and two-literal terms driven with both input polarities separate true literals from complement literals, and AND from OR. Random sparse masks, sparse steering and occasional bypasses then produce mixed, overlapping and conflicting claims, and a reference model checks the full outputs against them.

// File: rtl/pts_pkg.sv
package pts_pkg;
    parameter int N_IN      = 68;
    parameter int N_MC      = 32;
    parameter int PT_PER_CL = 5;
    parameter int SIDE      = 3;
    parameter int N_CTRL    = 3;

    localparam int LIT_W = 2 * N_IN;
    localparam int N_PT  = N_MC * PT_PER_CL;
    localparam int SPAN  = 2 * SIDE + 1;
endpackage

// File: rtl/pts_term_gen.sv
module pts_term_gen #(
    parameter int N_IN    = 68,
    parameter int N_TERMS = 160
) (
    input  logic [N_IN-1:0]              in_bus,
    input  logic [N_TERMS*2*N_IN-1:0]    mask,
    output logic [N_TERMS-1:0]           term
);
    localparam int LW = 2 * N_IN;

    logic [LW-1:0] lits;

    // Even literal: true input; odd literal: inverted input.
    always_comb begin
        for (int i = 0; i < N_IN; i++) begin
            lits[2*i]   = in_bus[i];
            lits[2*i+1] = ~in_bus[i];
        end
    end

    for (genvar t = 0; t < N_TERMS; t++) begin : g_term
        // Unselected literals are forced to 1, so an empty mask gives 1.
        assign term[t] = &(~mask[t*LW +: LW] | lits);

        always_comb begin
            if (mask[t*LW +: LW] == '0) begin
                a_r2_empty_term_true: assert (term[t] == 1'b1)
                    else $error("empty-mask term %0d not 1", t);
            end
        end
    end
endmodule

// File: rtl/pts_claim_resolver.sv
module pts_claim_resolver #(
    parameter int N_MC = 32,
    parameter int SIDE = 3
) (
    input  logic [N_MC*(2*SIDE+1)-1:0]   take,
    input  logic [N_MC-1:0]              bypass,
    output logic [N_MC-1:0][N_MC-1:0]    grant,     // [macrocell][cluster]
    output logic [N_MC-1:0]              conflict   // per cluster
);
    localparam int SPAN = 2 * SIDE + 1;

    logic [N_MC-1:0][N_MC-1:0] claim;      // [macrocell][cluster]
    logic [N_MC-1:0]           seen;
    logic [N_MC-1:0][N_MC-1:0] col_claim;  // [cluster][macrocell]
    logic [N_MC-1:0][N_MC-1:0] col_grant;  // [cluster][macrocell]

    // Each macrocell claims its own cluster (bypass) or a window of neighbours.
    always_comb begin
        claim = '0;
        for (int m = 0; m < N_MC; m++) begin
            if (bypass[m]) begin
                claim[m][m] = 1'b1;
            end else begin
                for (int k = 0; k < SPAN; k++) begin
                    if (take[m*SPAN + k])
                        claim[m][(m + k + N_MC - SIDE) % N_MC] = 1'b1;
                end
            end
        end
    end

    // A second claimant on a cluster marks it as a conflict.
    always_comb begin
        seen     = '0;
        conflict = '0;
        for (int m = 0; m < N_MC; m++) begin
            for (int c = 0; c < N_MC; c++) begin
                conflict[c] = conflict[c] | (seen[c] & claim[m][c]);
                seen[c]     = seen[c] | claim[m][c];
            end
        end
    end

    always_comb begin
        for (int m = 0; m < N_MC; m++)
            for (int c = 0; c < N_MC; c++)
                grant[m][c] = claim[m][c] & ~conflict[c];
    end

    always_comb begin
        for (int c = 0; c < N_MC; c++)
            for (int m = 0; m < N_MC; m++) begin
                col_claim[c][m] = claim[m][c];
                col_grant[c][m] = grant[m][c];
            end
    end

    for (genvar c = 0; c < N_MC; c++) begin : g_chk
        always_comb begin
            a_r7_single_owner: assert ($onehot0(col_grant[c]))
                else $error("cluster %0d granted to several macrocells", c);
            a_r7_flag_needs_two: assert (conflict[c] == ($countones(col_claim[c]) >= 2))
                else $error("cluster %0d conflict flag disagrees with claims", c);
        end
    end
endmodule

// File: rtl/pts_sum_router.sv
module pts_sum_router #(
    parameter int N_MC      = 32,
    parameter int PT_PER_CL = 5
) (
    input  logic [N_MC*PT_PER_CL-1:0]    term,
    input  logic [N_MC-1:0][N_MC-1:0]    grant,
    output logic [N_MC-1:0]              sum
);
    logic [N_MC-1:0] cl_any;

    for (genvar c = 0; c < N_MC; c++) begin : g_cl
        assign cl_any[c] = |term[c*PT_PER_CL +: PT_PER_CL];
    end

    for (genvar m = 0; m < N_MC; m++) begin : g_mc
        assign sum[m] = |(grant[m] & cl_any);

        always_comb begin
            if (grant[m] == '0) begin
                a_r8_no_grant_zero: assert (sum[m] == 1'b0)
                    else $error("macrocell %0d high with no cluster", m);
            end
        end
    end
endmodule

// File: rtl/pts_array.sv
module pts_array
    import pts_pkg::*;
#(
    parameter int P_N_IN      = N_IN,
    parameter int P_N_MC      = N_MC,
    parameter int P_PT_PER_CL = PT_PER_CL,
    parameter int P_SIDE      = SIDE,
    parameter int P_N_CTRL    = N_CTRL
) (
    input  logic [P_N_IN-1:0]                              pt_in,
    input  logic [P_N_MC*P_PT_PER_CL*2*P_N_IN-1:0]         lit_mask,
    input  logic [P_N_CTRL*2*P_N_IN-1:0]                   ctrl_mask,
    input  logic [P_N_MC*(2*P_SIDE+1)-1:0]                 take_sel,
    input  logic [P_N_MC-1:0]                              bypass_en,
    output logic [P_N_MC-1:0]                              mc_sum,
    output logic [P_N_CTRL-1:0]                            ctrl_pt,
    output logic [P_N_MC-1:0]                              claim_err
);
    localparam int L_TERMS = P_N_MC * P_PT_PER_CL;

    logic [L_TERMS-1:0]            term;
    logic [P_N_MC-1:0][P_N_MC-1:0] grant;

    pts_term_gen #(.N_IN(P_N_IN), .N_TERMS(L_TERMS)) u_logic_terms (
        .in_bus (pt_in),
        .mask   (lit_mask),
        .term   (term)
    );

    pts_term_gen #(.N_IN(P_N_IN), .N_TERMS(P_N_CTRL)) u_ctrl_terms (
        .in_bus (pt_in),
        .mask   (ctrl_mask),
        .term   (ctrl_pt)
    );

    pts_claim_resolver #(.N_MC(P_N_MC), .SIDE(P_SIDE)) u_resolver (
        .take     (take_sel),
        .bypass   (bypass_en),
        .grant    (grant),
        .conflict (claim_err)
    );

    pts_sum_router #(.N_MC(P_N_MC), .PT_PER_CL(P_PT_PER_CL)) u_router (
        .term  (term),
        .grant (grant),
        .sum   (mc_sum)
    );

    always_comb begin
        if (take_sel == '0 && bypass_en == '0) begin
            a_r8_idle_all_low: assert (mc_sum == '0 && claim_err == '0)
                else $error("outputs active with no claims");
        end
    end

    for (genvar m = 0; m < P_N_MC; m++) begin : g_byp_chk
        always_comb begin
            if (bypass_en[m] && !claim_err[m] && |term[m*P_PT_PER_CL +: P_PT_PER_CL]) begin
                a_r6_bypass_own_cluster: assert (mc_sum[m] == 1'b1)
                    else $error("bypassed macrocell %0d lost its own cluster", m);
            end
        end
    end
endmodule

// File: tb/tb_pts_array.sv
module tb_pts_array;
    import pts_pkg::*;

    logic clk = 1'b0;
    always #10 clk = ~clk;   // 50 MHz

    logic [N_IN-1:0]          pt_in;
    logic [N_PT*LIT_W-1:0]    lit_mask;
    logic [N_CTRL*LIT_W-1:0]  ctrl_mask;
    logic [N_MC*SPAN-1:0]     take_sel;
    logic [N_MC-1:0]          bypass_en;
    logic [N_MC-1:0]          mc_sum;
    logic [N_CTRL-1:0]        ctrl_pt;
    logic [N_MC-1:0]          claim_err;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [N_MC-1:0]   exp_sum;
    logic [N_MC-1:0]   exp_err;
    logic [N_CTRL-1:0] exp_ctrl;

    pts_array dut (
        .pt_in     (pt_in),
        .lit_mask  (lit_mask),
        .ctrl_mask (ctrl_mask),
        .take_sel  (take_sel),
        .bypass_en (bypass_en),
        .mc_sum    (mc_sum),
        .ctrl_pt   (ctrl_pt),
        .claim_err (claim_err)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic settle();
        @(negedge clk);
        #2;
    endtask

    function automatic bit eval_term(input logic [LIT_W-1:0] m);
        bit v = 1'b1;
        for (int j = 0; j < LIT_W; j++)
            if (m[j]) v &= (j % 2 == 1) ? ~pt_in[j/2] : pt_in[j/2];
        return v;
    endfunction

    task automatic model();
        logic [N_MC-1:0] cl_live;
        int cnt [N_MC];
        logic [N_MC-1:0][N_MC-1:0] cl;
        cl = '0;
        for (int c = 0; c < N_MC; c++) begin
            cl_live[c] = 1'b0;
            for (int p = 0; p < PT_PER_CL; p++)
                cl_live[c] |= eval_term(lit_mask[(c*PT_PER_CL+p)*LIT_W +: LIT_W]);
            cnt[c] = 0;
        end
        for (int m = 0; m < N_MC; m++) begin
            if (bypass_en[m]) cl[m][m] = 1'b1;
            else for (int k = 0; k < SPAN; k++)
                if (take_sel[m*SPAN+k]) cl[m][(m + k - SIDE + N_MC) % N_MC] = 1'b1;
            for (int c = 0; c < N_MC; c++) if (cl[m][c]) cnt[c]++;
        end
        for (int c = 0; c < N_MC; c++) exp_err[c] = (cnt[c] > 1);
        for (int m = 0; m < N_MC; m++) begin
            exp_sum[m] = 1'b0;
            for (int c = 0; c < N_MC; c++)
                if (cl[m][c] && cnt[c] == 1 && cl_live[c]) exp_sum[m] = 1'b1;
        end
        for (int j = 0; j < N_CTRL; j++)
            exp_ctrl[j] = eval_term(ctrl_mask[j*LIT_W +: LIT_W]);
    endtask

    task automatic clear_cfg();
        lit_mask = '0; ctrl_mask = '0; take_sel = '0; bypass_en = '0; pt_in = '0;
    endtask

    // Every logic term becomes x & ~x, i.e. constant 0.
    task automatic kill_all();
        lit_mask = '0;
        for (int t = 0; t < N_PT; t++) begin
            lit_mask[t*LIT_W]     = 1'b1;
            lit_mask[t*LIT_W + 1] = 1'b1;
        end
    endtask

    task automatic live_term(input int t);
        lit_mask[t*LIT_W +: LIT_W] = '0;
    endtask

    task automatic live_cluster(input int c);
        for (int p = 0; p < PT_PER_CL; p++) live_term(c*PT_PER_CL + p);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        clear_cfg();
        settle();
        // Reset state: nothing claimed, empty control masks
        chk("R8 idle sums", mc_sum, 0);
        chk("R7 idle errors", claim_err, 0);
        chk("R2 empty ctrl terms", ctrl_pt, 3'b111);

        // R1: literal polarity and AND
        kill_all();
        lit_mask[0 +: LIT_W] = '0;
        lit_mask[2*5] = 1'b1;            // in[5] true
        bypass_en[0] = 1'b1;
        pt_in[5] = 1'b1; settle();
        chk("R1 true literal high", mc_sum[0], 1);
        pt_in[5] = 1'b0; #3;
        chk("R10 follows input without clock", mc_sum[0], 0);
        lit_mask[0 +: LIT_W] = '0;
        lit_mask[2*5+1] = 1'b1;          // in[5] inverted
        settle();
        chk("R1 complement literal", mc_sum[0], 1);
        lit_mask[2*7] = 1'b1;            // AND in[7]
        settle();
        chk("R1 AND one false", mc_sum[0], 0);
        pt_in[7] = 1'b1; settle();
        chk("R1 AND both true", mc_sum[0], 1);

        // R4: wrap-around in both directions
        clear_cfg(); kill_all();
        live_cluster(29);
        take_sel[0*SPAN + 0] = 1'b1;     // m0 offset -3 -> cluster 29
        settle();
        chk("R4 wrap low", mc_sum, 32'h0000_0001);
        take_sel = '0;
        take_sel[0*SPAN + 4] = 1'b1;     // m0 offset +1 -> cluster 1 (dead)
        settle();
        chk("R4 wrong cluster dead", mc_sum, 0);
        kill_all(); live_cluster(2);
        take_sel = '0;
        take_sel[31*SPAN + 6] = 1'b1;    // m31 offset +3 -> cluster 2
        settle();
        chk("R4 wrap high", mc_sum, 32'h8000_0000);

        // R5: seven clusters, far terms of both edges
        clear_cfg(); kill_all();
        take_sel[10*SPAN +: SPAN] = '1;  // clusters 7..13
        live_term(13*PT_PER_CL + 4);
        settle();
        chk("R5 far upper term", mc_sum, 32'h0000_0400);
        kill_all(); live_term(7*PT_PER_CL);
        settle();
        chk("R5 far lower term", mc_sum, 32'h0000_0400);
        kill_all(); live_cluster(14);
        settle();
        chk("R5 outside window", mc_sum, 0);

        // R6: bypass ignores steering
        clear_cfg(); kill_all();
        bypass_en[5] = 1'b1;
        take_sel[5*SPAN + 4] = 1'b1;     // would be cluster 6
        live_cluster(6);
        settle();
        chk("R6 steering ignored", mc_sum, 0);
        kill_all(); live_cluster(5);
        settle();
        chk("R6 own cluster used", mc_sum, 32'h0000_0020);

        // R7: double claim
        clear_cfg(); kill_all();
        live_cluster(4);
        take_sel[3*SPAN + 4] = 1'b1;     // m3 -> cluster 4
        bypass_en[4] = 1'b1;             // m4 -> cluster 4
        settle();
        chk("R7 conflict starves", mc_sum, 0);
        chk("R7 conflict flagged", claim_err, 32'h0000_0010);
        take_sel = '0;
        settle();
        chk("R7 single owner", mc_sum, 32'h0000_0010);
        chk("R7 flag clears", claim_err, 0);

        // R9: control terms independent of steering
        clear_cfg();
        ctrl_mask[1*LIT_W + 2*2] = 1'b1; // ctrl1 = in[2]
        take_sel = '1; bypass_en = '1;
        settle();
        chk("R9 ctrl low", ctrl_pt, 3'b101);
        pt_in[2] = 1'b1; take_sel = '0; bypass_en = '0;
        settle();
        chk("R9 ctrl high", ctrl_pt, 3'b111);

        // R3: random sparse configurations against the model
        for (int it = 0; it < 250; it++) begin
            lit_mask = '0; ctrl_mask = '0;
            for (int t = 0; t < N_PT; t++)
                for (int n = 0; n < int'($urandom % 3); n++)
                    lit_mask[t*LIT_W + int'($urandom % LIT_W)] = 1'b1;
            for (int j = 0; j < N_CTRL; j++)
                ctrl_mask[j*LIT_W + int'($urandom % LIT_W)] = 1'b1;
            for (int m = 0; m < N_MC; m++) begin
                take_sel[m*SPAN +: SPAN] = SPAN'($urandom & $urandom & $urandom);
                bypass_en[m] = (($urandom % 8) == 0);
            end
            pt_in = {$urandom, $urandom, $urandom};
            settle();
            model();
            chk("R3 random sums", mc_sum, exp_sum);
            chk("R7 random flags", claim_err, exp_err);
            chk("R9 random ctrl", ctrl_pt, exp_ctrl);
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule